// File: doc/BRIEF.md
# Register Scan Bus Bridge with Local Default Responder

This block connects a host memory-mapped slave port to an internal bus of 64-bit scan registers. The host presents a byte address and a transfer size. The bridge takes the register index from the address, which is the address shifted right by three. A fixed group of housekeeping indices is answered locally. These cover a read-only chip identifier, registers that always read as zero, and registers whose writes are thrown away. Every other access goes to a downstream register bus as a request and response pair. The downstream byte address is the index shifted left by three.

The host side uses a single-phase handshake. The host raises `h_valid` with the address, size and write data, and holds them there. The bridge keeps `h_ready` low until the access has resolved, then raises it for exactly one cycle with `h_rdata` and `h_err`. Host data is big-endian, while the downstream bus carries register values in native order, so the bridge reverses bytes in both directions. Each completed access ORs a DONE bit into a sticky two-bit status word, and also a FAIL bit when the access failed. Software clears the status bits through a separate write-one-to-clear input.

The controller has four states:
- `ST_IDLE`: waits for `h_valid`. Here the access is either resolved locally (`ST_IDLE -> ST_REPLY`) or sent downstream (`ST_IDLE -> ST_DREQ`).
- `ST_DREQ`: holds the downstream request until it is accepted (`ST_DREQ -> ST_DRSP`).
- `ST_DRSP`: waits for the downstream response (`ST_DRSP -> ST_REPLY`).
- `ST_REPLY`: returns the result to the host and updates the status word (`ST_REPLY -> ST_IDLE`).

A wait timer runs in `ST_DREQ` and `ST_DRSP`. When it expires, the controller takes `ST_DREQ -> ST_REPLY` or `ST_DRSP -> ST_REPLY` with a failure.

Top module: `regscan_bridge`

## Requirements
- R1: An access is rejected with `h_err`=1 and never goes downstream in either of two cases: `h_size` is not 8 (bytes), or `h_addr[2:0]` is not zero. For a read, `h_rdata` is then 0.
- R2: A forwarded access drives `d_addr` = (`h_addr` >> 3) << 3 and `d_write` equal to `h_write`.
- R3: The bytes of `d_wdata` are the bytes of `h_wdata` in reverse order. The bytes of `h_rdata` on a successful forwarded read are the bytes of `d_rdata` in reverse order.
- R4: A read of index 0xF000F returns the parameter CHIP_ID in reversed byte order with no error. A write to index 0xF000F completes without error and goes nowhere.
- R5: Reads of the following indices return 0 with no error and never go downstream: 0x18002, 0x1010C00, 0x1010C03, 0x1020013, 0x1020014, 0xF0033, 0xF0034, 0x90012, 0x90013, 0x90018, 0x2020007, 0x2020009, 0x202000F, 0x2013F01, 0x2013F05, 0x2013028, 0x201302A, 0x2013801, 0x2013802, 0x2010828, 0x201082A, 0x2010841, 0x2010842, 0x4010828, 0x401082A, 0x4010841, 0x4010842.
- R6: Writes to the R5 indices are dropped without error and never go downstream, except for 0x18002, 0x2013F01 and 0x2013F05, which are forwarded. Writes to 0x1010C01, 0x1010C02, 0x1010C04 and 0x1010C05 are also dropped, but reads of those four indices are forwarded.
- R7: While a forwarded access is pending, `h_ready` stays low. `d_req_valid` is held with a stable `d_addr` until `d_req_ready` is seen. `d_rsp_ready` is high only after the request has been accepted.
- R8: Every completed access sets `stat[0]` (DONE) in the cycle after `h_ready`.
- R9: A downstream response with `d_rsp_err`=1 gives `h_err`=1, `h_rdata`=0, and sets both `stat[1]` (FAIL) and `stat[0]`. An R1 rejection sets the same two bits.
- R10: Status bits only accumulate. A bit falls only when `stat_clr` has a 1 in that position. When a set and a clear hit the same bit in the same cycle, the set wins.
- R11: If no downstream response has completed TIMEOUT cycles after the request was first raised, the access ends with `h_err`=1, `h_rdata`=0 and FAIL|DONE set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_valid | input | 1 | Host access request, held until `h_ready` |
| h_ready | output | 1 | One-cycle completion strobe to the host |
| h_write | input | 1 | 1 = write, 0 = read |
| h_addr | input | IDX_W+3 | Host byte address |
| h_size | input | 4 | Transfer size in bytes |
| h_wdata | input | 64 | Host write data, big-endian |
| h_rdata | output | 64 | Host read data, big-endian, valid with `h_ready` |
| h_err | output | 1 | Error flag, valid with `h_ready` |
| d_req_valid | output | 1 | Downstream request valid |
| d_req_ready | input | 1 | Downstream request accepted |
| d_write | output | 1 | Downstream direction |
| d_addr | output | IDX_W+3 | Downstream byte address |
| d_wdata | output | 64 | Downstream write data, native order |
| d_rsp_valid | input | 1 | Downstream response valid |
| d_rsp_ready | output | 1 | Bridge ready for the response |
| d_rsp_err | input | 1 | Downstream access failed |
| d_rdata | input | 64 | Downstream read data, native order |
| stat_clr | input | 2 | Write-one-to-clear mask for `stat` |
| stat | output | 2 | Sticky status: bit 0 DONE, bit 1 FAIL |

## Verification
Every local index is swept with both reads and writes. This separates the read-zero group from the write-drop group, and the sweep includes the indices that belong to only one of the two groups. Forwarded reads use walking-one indices and several request and response latencies. This catches address bits that are lost or shifted, and byte lanes that are swapped. All sixteen size codes are tried, together with misaligned addresses, to check that the rejection path never touches the downstream bus. A downstream error, a silent target, and a status clear that lands in the same cycle as a set cover the failure and sticky-status behaviour.

// File: rtl/regscan_pkg.sv
package regscan_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DREQ  = 2'd1,
        ST_DRSP  = 2'd2,
        ST_REPLY = 2'd3
    } bridge_state_e;

    localparam int STAT_DONE = 0;
    localparam int STAT_FAIL = 1;
    localparam int STAT_W = 2;
    localparam logic [3:0] WORD_BYTES = 4'd8;
    localparam int DATA_W = 64;
endpackage

// File: rtl/regscan_swap.sv
module regscan_swap #(
    parameter int BYTES = 8,
    localparam int W = BYTES * 8
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        assign dout[b*8 +: 8] = din[(BYTES-1-b)*8 +: 8];
    end
endmodule

// File: rtl/regscan_decode.sv
module regscan_decode #(
    parameter int          IDX_W   = 28,
    parameter logic [63:0] CHIP_ID = 64'h0
) (
    input  logic [IDX_W-1:0] idx,
    output logic             rd_local,
    output logic [63:0]      rd_value,
    output logic             wr_drop
);
    logic [31:0] key;
    logic        is_chip;
    logic        rd_zero;
    logic        wr_only;
    logic        rd_only;
    logic [63:0] chip_be;

    assign key = {{(32-IDX_W){1'b0}}, idx};

    regscan_swap #(.BYTES(8)) u_chip_swap (.din(CHIP_ID), .dout(chip_be));

    always_comb begin
        is_chip = (key == 32'h000F_000F);
        rd_zero = 1'b0;
        rd_only = 1'b0;
        wr_only = 1'b0;
        case (key)
            32'h0001_8002, 32'h0201_3F01, 32'h0201_3F05:
                rd_only = 1'b1;
            32'h0101_0C01, 32'h0101_0C02, 32'h0101_0C04, 32'h0101_0C05:
                wr_only = 1'b1;
            32'h0101_0C00, 32'h0101_0C03, 32'h0102_0013, 32'h0102_0014,
            32'h000F_0033, 32'h000F_0034, 32'h0009_0012, 32'h0009_0013,
            32'h0009_0018, 32'h0202_0007, 32'h0202_0009, 32'h0202_000F,
            32'h0201_3028, 32'h0201_302A, 32'h0201_3801, 32'h0201_3802,
            32'h0201_0828, 32'h0201_082A, 32'h0201_0841, 32'h0201_0842,
            32'h0401_0828, 32'h0401_082A, 32'h0401_0841, 32'h0401_0842:
                rd_zero = 1'b1;
            default: ;
        endcase
        rd_local = is_chip | rd_zero | rd_only;
        wr_drop  = is_chip | rd_zero | wr_only;
        rd_value = is_chip ? chip_be : 64'h0;
    end
endmodule

// File: rtl/regscan_timer.sv
module regscan_timer #(
    parameter int TIMEOUT = 1024,
    localparam int CW = $clog2(TIMEOUT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt_q <= '0;
        else if (!expired)  cnt_q <= cnt_q + 1'b1;
    end

    assign expired = run && (cnt_q == CW'(TIMEOUT - 1));
endmodule

// File: rtl/regscan_bridge.sv
module regscan_bridge
    import regscan_pkg::*;
#(
    parameter int          IDX_W   = 28,
    parameter int          TIMEOUT = 1024,
    parameter logic [63:0] CHIP_ID = 64'h0,
    localparam int         HA_W    = IDX_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_valid,
    output logic              h_ready,
    input  logic              h_write,
    input  logic [HA_W-1:0]   h_addr,
    input  logic [3:0]        h_size,
    input  logic [63:0]       h_wdata,
    output logic [63:0]       h_rdata,
    output logic              h_err,
    output logic              d_req_valid,
    input  logic              d_req_ready,
    output logic              d_write,
    output logic [HA_W-1:0]   d_addr,
    output logic [63:0]       d_wdata,
    input  logic              d_rsp_valid,
    output logic              d_rsp_ready,
    input  logic              d_rsp_err,
    input  logic [63:0]       d_rdata,
    input  logic [STAT_W-1:0] stat_clr,
    output logic [STAT_W-1:0] stat
);
    bridge_state_e st_q, st_d;

    logic [IDX_W-1:0]  idx_q;
    logic              wr_q;
    logic [63:0]       wdata_q;
    logic [63:0]       rdata_q;
    logic              err_q;
    logic [STAT_W-1:0] stat_q;

    logic [IDX_W-1:0]  idx_in;
    logic              bad_shape;
    logic              rd_local, wr_drop, local_hit;
    logic [63:0]       local_value;
    logic [63:0]       wdata_native, rdata_be;
    logic              tmo;

    assign idx_in    = h_addr[HA_W-1:3];
    assign bad_shape = (h_size != WORD_BYTES) || (h_addr[2:0] != 3'b000);
    assign local_hit = h_write ? wr_drop : rd_local;

    regscan_decode #(.IDX_W(IDX_W), .CHIP_ID(CHIP_ID)) u_decode (
        .idx      (idx_in),
        .rd_local (rd_local),
        .rd_value (local_value),
        .wr_drop  (wr_drop)
    );

    regscan_swap #(.BYTES(8)) u_wswap (.din(h_wdata), .dout(wdata_native));
    regscan_swap #(.BYTES(8)) u_rswap (.din(d_rdata), .dout(rdata_be));

    regscan_timer #(.TIMEOUT(TIMEOUT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     ((st_q == ST_DREQ) || (st_q == ST_DRSP)),
        .expired (tmo)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (h_valid) st_d = (bad_shape || local_hit) ? ST_REPLY : ST_DREQ;
            ST_DREQ:  if (d_req_ready) st_d = ST_DRSP;
                      else if (tmo)    st_d = ST_REPLY;
            ST_DRSP:  if (d_rsp_valid || tmo) st_d = ST_REPLY;
            ST_REPLY: st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= '0;
            wr_q    <= 1'b0;
            wdata_q <= '0;
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (h_valid) begin
                    idx_q   <= idx_in;
                    wr_q    <= h_write;
                    wdata_q <= wdata_native;
                    err_q   <= bad_shape;
                    rdata_q <= (bad_shape || h_write) ? 64'h0 : local_value;
                end
                ST_DREQ: if (!d_req_ready && tmo) begin
                    err_q   <= 1'b1;
                    rdata_q <= 64'h0;
                end
                ST_DRSP: if (d_rsp_valid) begin
                    err_q   <= d_rsp_err;
                    rdata_q <= (d_rsp_err || wr_q) ? 64'h0 : rdata_be;
                end else if (tmo) begin
                    err_q   <= 1'b1;
                    rdata_q <= 64'h0;
                end
                ST_REPLY: ;
                default: ;
            endcase
        end
    end

    // sticky status, set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= stat_q & ~stat_clr;
            if (st_q == ST_REPLY) begin
                stat_q[STAT_DONE] <= 1'b1;
                if (err_q) stat_q[STAT_FAIL] <= 1'b1;
                else       stat_q[STAT_FAIL] <= stat_q[STAT_FAIL] & ~stat_clr[STAT_FAIL];
            end
        end
    end

    // outputs
    always_comb begin
        h_ready     = (st_q == ST_REPLY);
        h_err       = err_q;
        h_rdata     = rdata_q;
        d_req_valid = (st_q == ST_DREQ);
        d_rsp_ready = (st_q == ST_DRSP);
        d_write     = wr_q;
        d_addr      = {idx_q, 3'b000};
        d_wdata     = wdata_q;
        stat        = stat_q;
    end
endmodule

// File: rtl/regscan_bridge_chk.sv
module regscan_bridge_chk #(
    parameter int HA_W = 31
) (
    input logic            clk,
    input logic            rst_n,
    input logic            h_ready,
    input logic            h_write,
    input logic            h_err,
    input logic [63:0]     h_rdata,
    input logic            d_req_valid,
    input logic            d_req_ready,
    input logic [HA_W-1:0] d_addr,
    input logic            d_rsp_ready,
    input logic [1:0]      stat_clr,
    input logic [1:0]      stat
);
    // R7: request held with stable address until accepted or abandoned
    assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        d_req_valid && !d_req_ready |=> (d_req_valid && $stable(d_addr)) || h_ready);

    // R7: request and response phases never overlap, host stalled meanwhile
    assert_phase_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (d_req_valid || d_rsp_ready) |-> !(d_req_valid && d_rsp_ready) && !h_ready);

    // R8: every completion sets DONE
    assert_done_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        h_ready |=> stat[0]);

    // R9: every failed completion sets FAIL
    assert_fail_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        h_ready && h_err |=> stat[1] && stat[0]);

    // R9: failed reads return zero data
    assert_err_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        h_ready && h_err && !h_write |-> h_rdata == 64'h0);

    // R10: bits fall only under a clear request
    assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~stat & $past(stat) & ~$past(stat_clr)) == 2'b00));
endmodule

bind regscan_bridge regscan_bridge_chk #(.HA_W(HA_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .h_ready     (h_ready),
    .h_write     (h_write),
    .h_err       (h_err),
    .h_rdata     (h_rdata),
    .d_req_valid (d_req_valid),
    .d_req_ready (d_req_ready),
    .d_addr      (d_addr),
    .d_rsp_ready (d_rsp_ready),
    .stat_clr    (stat_clr),
    .stat        (stat)
);

// File: tb/test_regscan_bridge.sv
module test_regscan_bridge;
    localparam int CLK_PERIOD = 10;
    localparam int IDX_W = 28;
    localparam int HA_W = IDX_W + 3;
    localparam int TMO = 20;
    localparam logic [63:0] CID = 64'h0123_4567_89AB_CDEF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic h_valid = 1'b0, h_write = 1'b0;
    logic [HA_W-1:0] h_addr = '0;
    logic [3:0] h_size = 4'd8;
    logic [63:0] h_wdata = '0;
    logic h_ready, h_err;
    logic [63:0] h_rdata;
    logic d_req_valid, d_write, d_rsp_ready;
    logic [HA_W-1:0] d_addr;
    logic [63:0] d_wdata;
    logic d_req_ready;
    logic rsp_v = 1'b0, rsp_e = 1'b0;
    logic [63:0] rsp_d = '0;
    logic [1:0] stat_clr = 2'b00;
    logic [1:0] stat;

    int checks = 0, fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    regscan_bridge #(.IDX_W(IDX_W), .TIMEOUT(TMO), .CHIP_ID(CID)) i_regscan_bridge (
        .clk(clk), .rst_n(rst_n), .h_valid(h_valid), .h_ready(h_ready), .h_write(h_write),
        .h_addr(h_addr), .h_size(h_size), .h_wdata(h_wdata), .h_rdata(h_rdata), .h_err(h_err),
        .d_req_valid(d_req_valid), .d_req_ready(d_req_ready), .d_write(d_write), .d_addr(d_addr),
        .d_wdata(d_wdata), .d_rsp_valid(rsp_v), .d_rsp_ready(d_rsp_ready), .d_rsp_err(rsp_e),
        .d_rdata(rsp_d), .stat_clr(stat_clr), .stat(stat)
    );

    // downstream target model
    int gap_set = 0, lat = 0;
    logic silent = 1'b0;
    int gap_cnt = 0, wcnt = 0, dn_cnt = 0;
    logic pend = 1'b0;
    logic [HA_W-1:0] la = '0;
    logic lw = 1'b0;
    logic [63:0] lwd = '0;

    assign d_req_ready = (gap_cnt == 0);

    function automatic logic [63:0] dn_data(input logic [HA_W-1:0] a);
        logic [31:0] a32;
        a32 = {1'b0, a};
        return {a32 ^ 32'hA5A5_0000, ~a32};
    endfunction

    function automatic logic [63:0] bswap(input logic [63:0] v);
        logic [63:0] r;
        for (int b = 0; b < 8; b++) r[b*8 +: 8] = v[(7-b)*8 +: 8];
        return r;
    endfunction

    always @(posedge clk) begin
        if (!d_req_valid) gap_cnt <= gap_set;
        else if (gap_cnt != 0) gap_cnt <= gap_cnt - 1;
        if (d_req_valid && d_req_ready) begin
            dn_cnt <= dn_cnt + 1;
            la <= d_addr; lw <= d_write; lwd <= d_wdata;
            pend <= 1'b1; wcnt <= lat;
        end else if (h_ready) begin
            pend <= 1'b0; rsp_v <= 1'b0;
        end else if (rsp_v && d_rsp_ready) begin
            rsp_v <= 1'b0; pend <= 1'b0;
        end else if (pend && !rsp_v && !silent) begin
            if (wcnt == 0) begin
                rsp_v <= 1'b1;
                rsp_d <= dn_data(la);
                rsp_e <= (la[HA_W-1:HA_W-4] == 4'hE);
            end else wcnt <= wcnt - 1;
        end
    end

    task automatic check(input string req, input logic ok, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [HA_W-1:0] a, input logic [3:0] sz,
                          input logic [63:0] wd, output logic [63:0] rd, output logic er, output int cyc);
        @(negedge clk);
        h_valid = 1'b1; h_write = wr; h_addr = a; h_size = sz; h_wdata = wd;
        cyc = 0;
        rd = '0; er = 1'b1;
        while (cyc < 500) begin
            @(negedge clk);
            cyc++;
            if (h_ready) begin
                rd = h_rdata; er = h_err;
                break;
            end
        end
        h_valid = 1'b0;
    endtask

    localparam logic [27:0] RZ [27] = '{28'h0018002, 28'h1010C00, 28'h1010C03, 28'h1020013,
        28'h1020014, 28'h00F0033, 28'h00F0034, 28'h0090012, 28'h0090013, 28'h0090018,
        28'h2020007, 28'h2020009, 28'h202000F, 28'h2013F01, 28'h2013F05, 28'h2013028,
        28'h201302A, 28'h2013801, 28'h2013802, 28'h2010828, 28'h201082A, 28'h2010841,
        28'h2010842, 28'h4010828, 28'h401082A, 28'h4010841, 28'h4010842};
    localparam logic [27:0] WD [29] = '{28'h00F000F, 28'h1010C00, 28'h1010C01, 28'h1010C02,
        28'h1010C03, 28'h1010C04, 28'h1010C05, 28'h1020013, 28'h1020014, 28'h00F0033,
        28'h00F0034, 28'h0090012, 28'h0090013, 28'h0090018, 28'h2020007, 28'h2020009,
        28'h202000F, 28'h2013028, 28'h201302A, 28'h2013801, 28'h2013802, 28'h2010828,
        28'h201082A, 28'h2010841, 28'h2010842, 28'h4010828, 28'h401082A, 28'h4010841,
        28'h4010842};
    localparam logic [27:0] RFWD [7] = '{28'h1010C01, 28'h1010C02, 28'h1010C04, 28'h1010C05,
        28'h0018002 + 28'h0, 28'h2013F01, 28'h2013F05};

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        fails++; checks++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        logic [63:0] rd;
        logic er;
        int cyc, n0;
        logic [HA_W-1:0] a;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 reset", stat == 2'b00 && !h_ready && !d_req_valid, {62'h0, stat}, 64'h0);

        // R4 chip identifier
        access(1'b0, {28'h00F000F, 3'b0}, 4'd8, 0, rd, er, cyc);
        check("R4 chip id read", rd == bswap(CID) && !er, rd, bswap(CID));
        @(negedge clk);
        check("R8 done after local read", stat == 2'b01, {62'h0, stat}, 64'h1);

        // R5 read-zero sweep
        for (int i = 0; i < 27; i++) begin
            n0 = dn_cnt;
            access(1'b0, {RZ[i], 3'b0}, 4'd8, 0, rd, er, cyc);
            check("R5 read zero", rd == 0 && !er && dn_cnt == n0, rd, 64'h0);
        end
        // R6 write-drop sweep
        for (int i = 0; i < 29; i++) begin
            n0 = dn_cnt;
            access(1'b1, {WD[i], 3'b0}, 4'd8, 64'hFFFF_0000_1234_5678, rd, er, cyc);
            check("R6 write dropped", !er && dn_cnt == n0, 64'(dn_cnt - n0), 64'h0);
        end
        // R6 reads of write-only-drop indices and writes of read-only-zero indices go downstream
        for (int i = 0; i < 7; i++) begin
            n0 = dn_cnt;
            access(i >= 4, {RFWD[i], 3'b0}, 4'd8, 64'h1122_3344_5566_7788, rd, er, cyc);
            check("R6 forwarded", !er && dn_cnt == n0 + 1 && la == {RFWD[i], 3'b0} && lw == (i >= 4),
                  {33'h0, la}, {33'h0, RFWD[i], 3'b0});
        end

        // R2 R3 R7 walking-one forwarded reads and writes, varying latency
        for (int k = 0; k < 28; k++) begin
            gap_set = k % 3; lat = k % 4;
            a = {28'(1) << k, 3'b0};
            if (k == 16 || k == 19) a = a | {28'h0000003, 3'b0};
            n0 = dn_cnt;
            access(1'b0, a, 4'd8, 0, rd, er, cyc);
            check("R2 addr", dn_cnt == n0 + 1 && la == a && !lw, {33'h0, la}, {33'h0, a});
            check("R3 read swap", rd == bswap(dn_data(a)) && !er, rd, bswap(dn_data(a)));
            check("R7 stall", cyc >= 2 + gap_set + lat, 64'(cyc), 64'(2 + gap_set + lat));
            access(1'b1, a, 4'd8, {32'hCAFE_0000, 32'(k)}, rd, er, cyc);
            check("R3 write swap", lwd == bswap({32'hCAFE_0000, 32'(k)}) && lw && !er,
                  lwd, bswap({32'hCAFE_0000, 32'(k)}));
        end
        gap_set = 0; lat = 0;

        // R1 size and alignment sweep
        for (int s = 0; s < 16; s++) begin
            for (int m = 0; m < 8; m++) begin
                if (s == 8 && m == 0) continue;
                if (m != 0 && m != 5 && s != 8) continue;
                n0 = dn_cnt;
                stat_clr = 2'b11; @(negedge clk); stat_clr = 2'b00;
                access(1'b0, {28'h0000123, 3'(m)}, 4'(s), 0, rd, er, cyc);
                check("R1 rejected", er && rd == 0 && dn_cnt == n0, {63'h0, er}, 64'h1);
                @(negedge clk);
                check("R9 fail on reject", stat == 2'b11, {62'h0, stat}, 64'h3);
            end
        end

        // R10 clear
        stat_clr = 2'b01; @(negedge clk); stat_clr = 2'b00;
        check("R10 partial clear", stat == 2'b10, {62'h0, stat}, 64'h2);
        stat_clr = 2'b11; @(negedge clk); stat_clr = 2'b00;
        check("R10 full clear", stat == 2'b00, {62'h0, stat}, 64'h0);

        // R9 downstream error
        access(1'b0, {28'hE000001, 3'b0}, 4'd8, 0, rd, er, cyc);
        check("R9 dn error", er && rd == 0, rd, 64'h0);
        stat_clr = 2'b11;
        @(negedge clk);
        stat_clr = 2'b00;
        check("R10 set wins over clear", stat == 2'b11, {62'h0, stat}, 64'h3);
        stat_clr = 2'b11; @(negedge clk); stat_clr = 2'b00;
        access(1'b1, {28'hE000002, 3'b0}, 4'd8, 64'h5, rd, er, cyc);
        @(negedge clk);
        check("R9 write error status", er && stat == 2'b11, {62'h0, stat}, 64'h3);

        // R8 success leaves FAIL clear
        stat_clr = 2'b11; @(negedge clk); stat_clr = 2'b00;
        access(1'b0, {28'h0000777, 3'b0}, 4'd8, 0, rd, er, cyc);
        @(negedge clk);
        check("R8 done only", stat == 2'b01 && !er, {62'h0, stat}, 64'h1);

        // R11 timeout, silent target and stalled request
        silent = 1'b1;
        n0 = dn_cnt;
        access(1'b0, {28'h0000888, 3'b0}, 4'd8, 0, rd, er, cyc);
        @(negedge clk);
        check("R11 timeout response", er && rd == 0 && cyc >= TMO && dn_cnt == n0 + 1, 64'(cyc), 64'(TMO));
        check("R11 timeout status", stat == 2'b11, {62'h0, stat}, 64'h3);
        silent = 1'b0;
        gap_set = 1000;
        repeat (2) @(negedge clk);
        n0 = dn_cnt;
        access(1'b0, {28'h0000999, 3'b0}, 4'd8, 0, rd, er, cyc);
        check("R11 request timeout", er && dn_cnt == n0 && cyc >= TMO, 64'(cyc), 64'(TMO));
        gap_set = 0;
        repeat (2) @(negedge clk);
        access(1'b0, {28'h0000AAA, 3'b0}, 4'd8, 0, rd, er, cyc);
        check("R7 recovery after timeout", !er && rd == bswap(dn_data({28'h0000AAA, 3'b0})),
              rd, bswap(dn_data({28'h0000AAA, 3'b0})));

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule